// File: doc/BRIEF.md
# Coprocessor Host Register Window

This block is the byte-wide register window through which a host processor reaches a graphics coprocessor. The window spans 768 bytes of host address space. It holds sixteen 16-bit general registers, a status word, a set of 8-bit control registers, a 16-bit cache base register and a 512-byte cache RAM. The host drives an address, a write strobe with data, and a read strobe. Read data is combinational from the address, and every side effect takes place at the next rising clock edge.

The block tracks two flags in the status word. The run flag is raised when the host writes the high byte of the program counter (general register 15) and is dropped when the core signals a stop. The interrupt flag is raised by the core and cleared when the host reads the status high byte. The screen mode, config and clock control registers are decoded into side-band outputs for the core: pixel depth, screen height, RAM and ROM grants, multiplier speed and clock doubling. The core itself, memory arbitration and plotting sit outside this block.

Top module: `cop_host_regs`

## Requirements
- R1: Offsets 0x00 to 0x1F hold sixteen 16-bit registers, little-endian, two bytes each (register n low byte at 2n, high byte at 2n+1). A write changes only the addressed byte, and a read returns it.
- R2: A write to offset 0x1F sets status bit 5 (`core_go`) at the next edge, and a write to 0x1E does not. `core_stop` clears it. If both happen in the same cycle, the write wins.
- R3: `core_irq` sets status bit 15, which reads as bit 7 at offset 0x31. A host read of 0x31 returns the flag and clears it at the next edge. If `core_irq` comes in the same cycle, the flag stays set. All other status bits read zero, and the status bytes ignore writes.
- R4: `irq_out` is the interrupt flag gated by config bit 7: when that bit is 1, `irq_out` is 0.
- R5: Offset 0x3B always reads the `VERSION` parameter, and writes to it are ignored.
- R6: The cache base register sits at 0x3E (low byte) and 0x3F (high byte). Bits 3:0 of the low byte always read zero, and the other bits read back as written.
- R7: Offsets 0x20 to 0x2F, 0x32, 0x35, 0x3D, 0x40 to 0xFF and 0x300 to 0x3FF read zero and ignore writes.
- R8: `color_bits` decodes screen mode bits 1:0 at offset 0x3A: 00 gives 2, 01 gives 4, 11 gives 8, and 10 (unused) gives 0.
- R9: The height code {bit 5, bit 2} of the screen mode register selects `scr_lines`: 00 gives 128, 01 gives 160, 10 gives 192, and 11 gives 0 with `obj_mode` set to 1.
- R10: `core_owns_ram` follows screen mode bit 3, `core_owns_rom` follows screen mode bit 4, `fast_mul` follows config (0x37) bit 5, and `dbl_clk` follows clock register (0x39) bit 0.
- R11: Offsets 0x100 to 0x2FF read and write the 512-byte cache RAM, one byte per offset.
- R12: After reset, every stored byte, `core_go` and the interrupt flag are zero.
- R13: The 8-bit registers at 0x33, 0x34, 0x36, 0x37, 0x38, 0x39, 0x3A and 0x3C read back all eight bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 10 | Host byte offset into the window |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (drives read side effects) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at `host_addr` |
| core_stop | input | 1 | Core has executed a stop |
| core_irq | input | 1 | Core raises an interrupt |
| core_go | output | 1 | Run flag (status bit 5) |
| irq_out | output | 1 | Masked interrupt toward the host |
| color_bits | output | 4 | Bits per pixel, 0 when the mode is unused |
| scr_lines | output | 9 | Screen height in lines, 0 in OBJ mode |
| obj_mode | output | 1 | Height code selects OBJ layout |
| core_owns_ram | output | 1 | Game-pak RAM granted to the core |
| core_owns_rom | output | 1 | ROM granted to the core |
| fast_mul | output | 1 | High-speed multiplier selected |
| dbl_clk | output | 1 | Double clock speed selected |

## Verification
The assertions assume that `host_addr` and the strobes are stable and known across each clock edge, and that reads and writes never target the same byte in one cycle. The stimulus changes inputs only at the falling edge and asserts at most one of `host_wr` and `host_rd` per cycle. It drives `core_irq` and `core_stop` freely, including in the same cycle as the R15 high-byte write and the status-high read, so that the set-wins ordering is exercised.

// File: rtl/cop_regs_pkg.sv
package cop_regs_pkg;
  localparam logic [5:0] OFS_SFR_LO   = 6'h30;
  localparam logic [5:0] OFS_SFR_HI   = 6'h31;
  localparam logic [5:0] OFS_BKRAM    = 6'h33;
  localparam logic [5:0] OFS_PBANK    = 6'h34;
  localparam logic [5:0] OFS_RBANK    = 6'h36;
  localparam logic [5:0] OFS_CFG      = 6'h37;
  localparam logic [5:0] OFS_SBASE    = 6'h38;
  localparam logic [5:0] OFS_CLK      = 6'h39;
  localparam logic [5:0] OFS_SMODE    = 6'h3A;
  localparam logic [5:0] OFS_VER      = 6'h3B;
  localparam logic [5:0] OFS_ABANK    = 6'h3C;
  localparam logic [5:0] OFS_CBASE_LO = 6'h3E;
  localparam logic [5:0] OFS_CBASE_HI = 6'h3F;

  localparam int GO_BIT   = 5;
  localparam int IRQ_BIT  = 7;  // bit 15 of the status word, seen in its high byte
  localparam int MASK_BIT = 7;
  localparam int FMUL_BIT = 5;

  // pixel depth from the two mode bits
  function automatic logic [3:0] depth_bits(input logic [1:0] md);
    case (md)
      2'b00:   depth_bits = 4'd2;
      2'b01:   depth_bits = 4'd4;
      2'b11:   depth_bits = 4'd8;
      default: depth_bits = 4'd0;
    endcase
  endfunction

  // screen height from the height code {HT1,HT0}
  function automatic logic [8:0] lines_for(input logic [1:0] ht);
    case (ht)
      2'b00:   lines_for = 9'd128;
      2'b01:   lines_for = 9'd160;
      2'b10:   lines_for = 9'd192;
      default: lines_for = 9'd0;
    endcase
  endfunction
endpackage

// File: rtl/cop_gpr_file.sv
module cop_gpr_file #(
  parameter int COUNT = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  localparam int SEL_W = IDX_W - 1;

  logic [COUNT-1:0][15:0] word;
  logic [SEL_W-1:0]       sel;

  assign sel = idx[IDX_W-1:1];

  for (genvar g = 0; g < COUNT; g++) begin : g_reg
    logic [15:0] q;
    logic        hit;
    assign hit = wr_en && (sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (hit) begin
        if (idx[0])    q[15:8] <= wdata;
        else           q[7:0]  <= wdata;
      end
    end
    assign word[g] = q;
  end

  assign rdata = idx[0] ? word[sel][15:8] : word[sel][7:0];
endmodule

// File: rtl/cop_cache_ram.sv
module cop_cache_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/cop_ctrl_regs.sv
module cop_ctrl_regs
  import cop_regs_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [5:0] ofs,
  input  logic [7:0] wdata,
  input  logic       pc_hi_wr,
  input  logic       sfr_hi_rd,
  input  logic       core_irq,
  input  logic       core_stop,
  output logic [7:0] rdata,
  output logic       go,
  output logic       irq_flag,
  output logic [7:0] smode,
  output logic [7:0] cfg,
  output logic [7:0] clk_sel
);
  logic       go_q, irq_q;
  logic [7:0] bkram_q, pbank_q, rbank_q, cfg_q, sbase_q, clk_q, smode_q, abank_q;
  logic [7:0] cbase_hi_q;
  logic [3:0] cbase_lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (pc_hi_wr)       go_q <= 1'b1;
      else if (core_stop) go_q <= 1'b0;
      if (core_irq)       irq_q <= 1'b1;
      else if (sfr_hi_rd) irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bkram_q <= '0; pbank_q <= '0; rbank_q <= '0; cfg_q <= '0;
      sbase_q <= '0; clk_q <= '0; smode_q <= '0; abank_q <= '0;
      cbase_hi_q <= '0; cbase_lo_q <= '0;
    end else if (wr_en) begin
      case (ofs)
        OFS_BKRAM:    bkram_q    <= wdata;
        OFS_PBANK:    pbank_q    <= wdata;
        OFS_RBANK:    rbank_q    <= wdata;
        OFS_CFG:      cfg_q      <= wdata;
        OFS_SBASE:    sbase_q    <= wdata;
        OFS_CLK:      clk_q      <= wdata;
        OFS_SMODE:    smode_q    <= wdata;
        OFS_ABANK:    abank_q    <= wdata;
        OFS_CBASE_LO: cbase_lo_q <= wdata[7:4];
        OFS_CBASE_HI: cbase_hi_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ofs)
      OFS_SFR_LO:   rdata = 8'(go_q) << GO_BIT;
      OFS_SFR_HI:   rdata = 8'(irq_q) << IRQ_BIT;
      OFS_BKRAM:    rdata = bkram_q;
      OFS_PBANK:    rdata = pbank_q;
      OFS_RBANK:    rdata = rbank_q;
      OFS_CFG:      rdata = cfg_q;
      OFS_SBASE:    rdata = sbase_q;
      OFS_CLK:      rdata = clk_q;
      OFS_SMODE:    rdata = smode_q;
      OFS_VER:      rdata = VERSION;
      OFS_ABANK:    rdata = abank_q;
      OFS_CBASE_LO: rdata = {cbase_lo_q, 4'h0};
      OFS_CBASE_HI: rdata = cbase_hi_q;
      default:      rdata = 8'h00;
    endcase
  end

  assign go       = go_q;
  assign irq_flag = irq_q;
  assign smode    = smode_q;
  assign cfg      = cfg_q;
  assign clk_sel  = clk_q;
endmodule

// File: rtl/cop_host_regs.sv
module cop_host_regs
  import cop_regs_pkg::*;
#(
  parameter int         ADDR_W      = 10,
  parameter int         GPR_COUNT   = 16,
  parameter int         CACHE_BYTES = 512,
  parameter int         CACHE_BASE  = 256,
  parameter logic [7:0] VERSION     = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              core_stop,
  input  logic              core_irq,
  output logic              core_go,
  output logic              irq_out,
  output logic [3:0]        color_bits,
  output logic [8:0]        scr_lines,
  output logic              obj_mode,
  output logic              core_owns_ram,
  output logic              core_owns_rom,
  output logic              fast_mul,
  output logic              dbl_clk
);
  localparam int GPR_BYTES = GPR_COUNT * 2;
  localparam int GPR_IDX_W = $clog2(GPR_BYTES);
  localparam int CACHE_AW  = $clog2(CACHE_BYTES);
  localparam int PC_HI_OFS = GPR_BYTES - 1;
  localparam int CTRL_BLK  = 3;  // 16-byte block at 0x30

  // region decode
  logic in_gpr, in_ctrl, in_cache;
  logic [ADDR_W-1:0] cache_off;
  assign in_gpr    = host_addr < ADDR_W'(GPR_BYTES);
  assign in_ctrl   = (host_addr >> 4) == ADDR_W'(CTRL_BLK);
  assign in_cache  = (host_addr >= ADDR_W'(CACHE_BASE)) &&
                     (host_addr <  ADDR_W'(CACHE_BASE + CACHE_BYTES));
  assign cache_off = host_addr - ADDR_W'(CACHE_BASE);

  // named events for the checker
  logic pc_hi_wr, sfr_hi_rd, cfg_mask, irq_flag;
  assign pc_hi_wr  = host_wr && (host_addr == ADDR_W'(PC_HI_OFS));
  assign sfr_hi_rd = host_rd && in_ctrl && (host_addr[5:0] == OFS_SFR_HI);

  logic [7:0] gpr_rd, ctrl_rd, cache_rd;
  logic [7:0] smode, cfg, clk_sel;

  cop_gpr_file #(.COUNT(GPR_COUNT), .IDX_W(GPR_IDX_W)) u_gpr (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr && in_gpr),
    .idx(host_addr[GPR_IDX_W-1:0]), .wdata(host_wdata), .rdata(gpr_rd));

  cop_ctrl_regs #(.VERSION(VERSION)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr && in_ctrl),
    .ofs(host_addr[5:0]), .wdata(host_wdata),
    .pc_hi_wr(pc_hi_wr), .sfr_hi_rd(sfr_hi_rd),
    .core_irq(core_irq), .core_stop(core_stop),
    .rdata(ctrl_rd), .go(core_go), .irq_flag(irq_flag),
    .smode(smode), .cfg(cfg), .clk_sel(clk_sel));

  cop_cache_ram #(.DEPTH(CACHE_BYTES), .AW(CACHE_AW)) u_cache (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr && in_cache),
    .addr(cache_off[CACHE_AW-1:0]), .wdata(host_wdata), .rdata(cache_rd));

  always_comb begin
    if (in_gpr)        host_rdata = gpr_rd;
    else if (in_ctrl)  host_rdata = ctrl_rd;
    else if (in_cache) host_rdata = cache_rd;
    else               host_rdata = 8'h00;
  end

  assign cfg_mask      = cfg[MASK_BIT];
  assign irq_out       = irq_flag && !cfg_mask;
  assign color_bits    = depth_bits(smode[1:0]);
  assign scr_lines     = lines_for({smode[5], smode[2]});
  assign obj_mode      = smode[5] && smode[2];
  assign core_owns_ram = smode[3];
  assign core_owns_rom = smode[4];
  assign fast_mul      = cfg[FMUL_BIT];
  assign dbl_clk       = clk_sel[0];
endmodule

// File: rtl/cop_host_regs_chk.sv
module cop_host_regs_chk #(
  parameter int         ADDR_W  = 10,
  parameter logic [7:0] VERSION = 8'h04
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_rdata,
  input logic              core_irq,
  input logic              core_stop,
  input logic              core_go,
  input logic              irq_flag,
  input logic              irq_out,
  input logic              cfg_mask,
  input logic              pc_hi_wr,
  input logic              sfr_hi_rd
);
  // R2
  go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hi_wr |=> core_go);
  // R2
  go_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stop && !pc_hi_wr) |=> !core_go);
  // R3
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |=> irq_flag);
  // R3
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_hi_rd && !core_irq) |=> !irq_flag);
  // R4
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mask |-> !irq_out);
  // R5
  version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == ADDR_W'(8'h3B)) |-> (host_rdata == VERSION));
  // R6
  cbase_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == ADDR_W'(8'h3E)) |-> (host_rdata[3:0] == 4'h0));
  // R7
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_addr >> 4) == ADDR_W'(2)) |-> (host_rdata == 8'h00));
endmodule

bind cop_host_regs cop_host_regs_chk #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rdata(host_rdata),
  .core_irq(core_irq), .core_stop(core_stop), .core_go(core_go),
  .irq_flag(irq_flag), .irq_out(irq_out), .cfg_mask(cfg_mask),
  .pc_hi_wr(pc_hi_wr), .sfr_hi_rd(sfr_hi_rd));

// File: tb/sim_cop_host_regs.sv
module sim_cop_host_regs;
  localparam logic [7:0] VER = 8'h04;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       core_stop = 1'b0, core_irq = 1'b0;
  logic       core_go, irq_out, obj_mode, core_owns_ram, core_owns_rom, fast_mul, dbl_clk;
  logic [3:0] color_bits;
  logic [8:0] scr_lines;

  int checks = 0;
  int failures = 0;

  logic [7:0] win [0:1023];
  logic       m_go, m_irq;

  cop_host_regs #(.VERSION(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_stop(core_stop), .core_irq(core_irq), .core_go(core_go),
    .irq_out(irq_out), .color_bits(color_bits), .scr_lines(scr_lines),
    .obj_mode(obj_mode), .core_owns_ram(core_owns_ram),
    .core_owns_rom(core_owns_rom), .fast_mul(fast_mul), .dbl_clk(dbl_clk));

  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic bit is_store(int a);
    if (a < 32) return 1;
    if (a >= 256 && a < 768) return 1;
    case (a)
      'h33, 'h34, 'h36, 'h37, 'h38, 'h39, 'h3A, 'h3C, 'h3E, 'h3F: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] mdl_read(int a);
    if (a == 'h30) return m_go ? 8'h20 : 8'h00;
    if (a == 'h31) return m_irq ? 8'h80 : 8'h00;
    if (a == 'h3B) return VER;
    if (a == 'h3E) return win[a] & 8'hF0;
    if (is_store(a)) return win[a];
    return 8'h00;
  endfunction

  function automatic string tag_of(int a);
    if (a < 32) return "R1";
    if (a == 'h30 || a == 'h31) return "R3";
    if (a == 'h3B) return "R5";
    if (a == 'h3E || a == 'h3F) return "R6";
    if (a >= 256 && a < 768) return "R11";
    if (is_store(a)) return "R13";
    return "R7";
  endfunction

  function automatic int exp_depth(logic [7:0] m);
    if (m[1:0] == 2'b10) return 0;
    return 2 << m[1:0] - (m[1:0] == 2'b11 ? 1 : 0);
  endfunction

  function automatic int exp_lines(logic [7:0] m);
    int code = m[5] * 2 + m[2];
    return (code == 3) ? 0 : 128 + 32 * code;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_side();
    chk("R2 go", core_go, m_go);
    chk("R4 irq_out", irq_out, m_irq && !win['h37][7]);
    chk("R8 depth", color_bits, exp_depth(win['h3A]));
    chk("R9 lines", scr_lines, exp_lines(win['h3A]));
    chk("R9 obj", obj_mode, win['h3A][5] && win['h3A][2]);
    chk("R10 ram", core_owns_ram, win['h3A][3]);
    chk("R10 rom", core_owns_rom, win['h3A][4]);
    chk("R10 fmul", fast_mul, win['h37][5]);
    chk("R10 dclk", dbl_clk, win['h39][0]);
  endtask

  // one cycle: drive, check pre-edge view, apply the edge to the model
  task automatic op(int a, bit wr, bit rd, logic [7:0] d, bit irq, bit stop);
    @(negedge clk);
    host_addr = 10'(a); host_wr = wr; host_rd = rd; host_wdata = d;
    core_irq = irq; core_stop = stop;
    #1;
    chk(tag_of(a), host_rdata, mdl_read(a));
    check_side();
    @(posedge clk);
    if (wr && is_store(a)) win[a] = d;
    if (wr && a == 'h1F) m_go = 1'b1;
    else if (stop) m_go = 1'b0;
    if (irq) m_irq = 1'b1;
    else if (rd && a == 'h31) m_irq = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) win[i] = 8'h00;
    m_go = 1'b0; m_irq = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12: reset state across the control block and some cache bytes
    for (int a = 0; a < 64; a++) op(a, 0, 0, 0, 0, 0);
    op(256, 0, 0, 0, 0, 0);
    op(767, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R12 go", core_go, 0);
    chk("R12 irq", irq_out, 0);

    // R1: byte lanes of a register
    op('h04, 1, 0, 8'hA5, 0, 0);
    op('h05, 1, 0, 8'h3C, 0, 0);
    op('h04, 0, 1, 0, 0, 0);
    op('h05, 0, 1, 0, 0, 0);
    // R2: low byte of R15 does not start; high byte does; set wins over stop
    op('h1E, 1, 0, 8'h11, 0, 0);
    op('h1E, 0, 0, 0, 0, 0);
    op('h1F, 1, 0, 8'h22, 0, 1);
    op('h30, 0, 1, 0, 0, 0);
    op('h30, 0, 0, 0, 0, 1);
    op('h30, 0, 0, 0, 0, 0);
    // R3: set, read-clear, set wins over read-clear
    op('h31, 0, 0, 0, 1, 0);
    op('h31, 0, 1, 0, 1, 0);
    op('h31, 0, 1, 0, 0, 0);
    op('h31, 0, 0, 0, 0, 0);
    // R4: mask
    op('h31, 0, 0, 0, 1, 0);
    op('h37, 1, 0, 8'h80, 0, 0);
    op('h37, 1, 0, 8'h20, 0, 0);
    // R5 / R6 / R7 writes ignored
    op('h3B, 1, 0, 8'hFF, 0, 0);
    op('h3B, 0, 1, 0, 0, 0);
    op('h3E, 1, 0, 8'hFF, 0, 0);
    op('h3E, 0, 1, 0, 0, 0);
    op('h25, 1, 0, 8'h77, 0, 0);
    op('h25, 0, 1, 0, 0, 0);
    op('h300, 1, 0, 8'h77, 0, 0);
    op('h300, 0, 1, 0, 0, 0);
    // R8 / R9 every mode code
    for (int m = 0; m < 64; m++) op('h3A, 1, 0, 8'(m), 0, 0);
    op('h3A, 0, 0, 0, 0, 0);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom % 10;
      int a;
      bit wr, rd;
      if (sel < 5)      a = $urandom % 64;
      else if (sel < 8) a = 256 + ($urandom % 512);
      else              a = $urandom % 1024;
      wr = ($urandom % 2) == 1;
      rd = !wr && (($urandom % 2) == 1);
      op(a, wr, rd, 8'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0);
    end
    op(0, 0, 0, 0, 0, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule